// File: doc/BRIEF.md
# Tri-State Pulse Exclusive-OR Cell

This block models, at the event level, a clocked cell that collects two kinds of single-cycle data strobes into one signed three-level store. A strobe on `in_a` pushes the store toward plus one. A strobe on `in_b` pushes it toward minus one. When both inputs fire in one period they cancel, and the store ends at zero. A read strobe `rd` reports the store on two output strobes and starts a fresh period from zero.

A build-time parameter `MODE` picks the variant. In mode 0, the side that won fires its output and a tie fires nothing. Merging the two outputs with OR then gives exclusive-OR. In mode 1, the winning side fires alone and a tie fires both outputs. Merging with AND then gives exclusive-NOR. All signals are one-cycle strobes in the system clock domain.

The accumulator has three named states: `TS_ZERO`, `TS_POS` and `TS_NEG`.
- `TS_ZERO` moves to `TS_POS` on an A-only cycle and to `TS_NEG` on a B-only cycle.
- `TS_POS` moves to `TS_ZERO` on a B-only cycle.
- `TS_NEG` moves to `TS_ZERO` on an A-only cycle.
- Any other cycle without a read leaves the state where it is.
- A read cycle restarts the state from `TS_ZERO` and then applies that cycle's own data strobes.

Top module: `tsx_cell`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the store is `TS_ZERO` and `out_a`, `out_b` and `result` are low.
- R2: Outside a read cycle, an A-only cycle steps the store up one level (NEG to ZERO, ZERO to POS) and a B-only cycle steps it down one level (POS to ZERO, ZERO to NEG).
- R3: A cycle with both `in_a` and `in_b` high leaves the store unchanged.
- R4: An A-only cycle while at POS, or a B-only cycle while at NEG, has no effect (saturation).
- R5: A cycle with `rd` high reads the store as it stood before that cycle. The next period starts at ZERO, and data strobes in the read cycle count toward the next period.
- R6: `out_a` and `out_b` pulse only in the cycle right after a read cycle, for exactly one cycle, and never without a read.
- R7: With MODE=0, a read of POS gives `out_a` only, a read of NEG gives `out_b` only, and a read of ZERO gives neither.
- R8: With MODE=1, a read of POS gives `out_a` only, a read of NEG gives `out_b` only, and a read of ZERO gives both.
- R9: `result` is `out_a | out_b` with MODE=0 (exclusive-OR) and `out_a & out_b` with MODE=1 (exclusive-NOR).
- R10: Within one period, a single A strobe and a single B strobe give the same readout in either order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 1 | Data strobe that pushes the store positive |
| in_b | input | 1 | Data strobe that pushes the store negative |
| rd | input | 1 | Read strobe: reports the store and restarts the period |
| out_a | output | 1 | Output strobe for the A side |
| out_b | output | 1 | Output strobe for the B side |
| result | output | 1 | Merged exclusive-OR (mode 0) or exclusive-NOR (mode 1) strobe |

## Verification
The assertions check every cycle for these behaviours:
- single-step moves of the store, cancellation when both inputs fire, and saturation at the extremes;
- the restart to zero after a read;
- no output strobe without a read in the previous cycle;
- the mode-specific rules: mode 0 never fires both outputs, and mode 1 always fires at least one.

Some behaviours only the bench's scenarios can show. These are order independence across several cycles of a period, and data strobes in a read cycle landing in the next period. The bench also compares complete readouts of both variants, side by side, against a signed reference model over directed and random strobe patterns.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

    typedef enum logic [1:0] {
        TS_ZERO = 2'b00,
        TS_POS  = 2'b01,
        TS_NEG  = 2'b10
    } tri_state_e;

endpackage

// File: rtl/tsx_accum.sv
module tsx_accum
    import tsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       rd,
    output tri_state_e held
);

    tri_state_e state_q;
    tri_state_e state_d;
    tri_state_e base;
    logic       only_a;
    logic       only_b;

    assign only_a = in_a & ~in_b;
    assign only_b = in_b & ~in_a;

    // A read restarts the period; this cycle's data then applies to the new period.
    always_comb begin
        base    = rd ? TS_ZERO : state_q;
        state_d = base;
        unique case (base)
            TS_ZERO: begin
                if (only_a)      state_d = TS_POS;
                else if (only_b) state_d = TS_NEG;
            end
            TS_POS: begin
                if (only_b) state_d = TS_ZERO;
            end
            TS_NEG: begin
                if (only_a) state_d = TS_ZERO;
            end
            default: state_d = TS_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_ZERO;
        else        state_q <= state_d;
    end

    assign held = state_q;

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && in_a && !in_b && state_q == TS_ZERO) |=> state_q == TS_POS);

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && in_b && !in_a && state_q == TS_ZERO) |=> state_q == TS_NEG);

    assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && in_a && in_b) |=> $stable(state_q));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && in_a && !in_b && state_q == TS_POS) |=> state_q == TS_POS);

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !in_a && !in_b) |=> state_q == TS_ZERO);

endmodule

// File: rtl/tsx_readout.sv
module tsx_readout
    import tsx_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  tri_state_e held,
    output logic       out_a,
    output logic       out_b,
    output logic       result
);

    localparam logic TIE_LEVEL = (MODE != 0);

    logic dec_a;
    logic dec_b;

    always_comb begin
        dec_a = 1'b0;
        dec_b = 1'b0;
        unique case (held)
            TS_POS:  dec_a = 1'b1;
            TS_NEG:  dec_b = 1'b1;
            TS_ZERO: begin
                dec_a = TIE_LEVEL;
                dec_b = TIE_LEVEL;
            end
            default: begin
                dec_a = 1'b0;
                dec_b = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= 1'b0;
            out_b <= 1'b0;
        end else begin
            out_a <= rd & dec_a;
            out_b <= rd & dec_b;
        end
    end

    generate
        if (MODE == 0) begin : g_xor
            assign result = out_a | out_b;

            assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !(out_a && out_b));
        end else begin : g_xnor
            assign result = out_a & out_b;

            assert_always_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
                rd |=> (out_a || out_b));
        end
    endgenerate

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_a || out_b) |-> $past(rd));

    assert_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !(out_a || out_b));

    assert_pos_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && held == TS_POS) |=> (out_a && !out_b));

    assert_neg_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && held == TS_NEG) |=> (out_b && !out_a));

endmodule

// File: rtl/tsx_cell.sv
module tsx_cell
    import tsx_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic rd,
    output logic out_a,
    output logic out_b,
    output logic result
);

    tri_state_e held;

    tsx_accum u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  (in_a),
        .in_b  (in_b),
        .rd    (rd),
        .held  (held)
    );

    tsx_readout #(.MODE(MODE)) u_readout (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (rd),
        .held   (held),
        .out_a  (out_a),
        .out_b  (out_b),
        .result (result)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_a && !out_b && held == TS_ZERO));

endmodule

// File: tb/tsx_cell_bench.sv
`timescale 1ns/1ps
module tsx_cell_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic rd = 1'b0;
    logic x_a, x_b, x_r;
    logic n_a, n_b, n_r;

    int tests = 0;
    int fails = 0;
    int model = 0;
    logic [5:0] expv = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tsx_cell #(.MODE(0)) u_tsx_cell (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .rd(rd),
        .out_a(x_a), .out_b(x_b), .result(x_r)
    );

    tsx_cell #(.MODE(1)) u_tsx_cell_m1 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .rd(rd),
        .out_a(n_a), .out_b(n_b), .result(n_r)
    );

    function automatic int step(int s, bit a, bit b);
        if (a && !b) return (s < 1) ? s + 1 : 1;
        if (b && !a) return (s > -1) ? s - 1 : -1;
        return s;
    endfunction

    // Order: mode0 a,b,result, mode1 a,b,result
    function automatic logic [5:0] readout(int s);
        logic m0a, m0b, m1a, m1b;
        m0a = (s == 1);
        m0b = (s == -1);
        m1a = (s >= 0);
        m1b = (s <= 0);
        return {m0a, m0b, m0a | m0b, m1a, m1b, m1a & m1b};
    endfunction

    task automatic cyc(bit a, bit b, bit r, string tag);
        logic [5:0] act;
        @(negedge clk);
        act = {x_a, x_b, x_r, n_a, n_b, n_r};
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b", tag, act, expv);
        end
        in_a = a;
        in_b = b;
        rd   = r;
        if (r) begin
            expv  = readout(model);
            model = step(0, a, b);
        end else begin
            expv  = '0;
            model = step(model, a, b);
        end
    endtask

    initial begin
        #4ms;
        fails++;
        $display("FAIL watchdog: run incomplete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        tests++;
        if ({x_a, x_b, n_a, n_b} !== 4'b0) begin
            fails++;
            $display("FAIL R1: outputs in reset %b expected 0000", {x_a, x_b, n_a, n_b});
        end
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");
        cyc(0, 0, 1, "R1");   // empty period reads ZERO
        cyc(0, 0, 0, "R8");
        // A only, B only
        cyc(1, 0, 0, "R2"); cyc(0, 0, 1, "R2"); cyc(0, 0, 0, "R7");
        cyc(0, 1, 0, "R2"); cyc(0, 0, 1, "R2"); cyc(0, 0, 0, "R8");
        // both in one cycle
        cyc(1, 1, 0, "R3"); cyc(0, 0, 1, "R3"); cyc(0, 0, 0, "R9");
        // ordering
        cyc(1, 0, 0, "R10"); cyc(0, 0, 0, "R10"); cyc(0, 1, 0, "R10");
        cyc(0, 0, 1, "R10"); cyc(0, 0, 0, "R10");
        cyc(0, 1, 0, "R10"); cyc(0, 1, 0, "R10"); cyc(1, 0, 0, "R10");
        cyc(0, 0, 1, "R10"); cyc(0, 0, 0, "R10");
        // saturation
        cyc(1, 0, 0, "R4"); cyc(1, 0, 0, "R4"); cyc(1, 0, 0, "R4");
        cyc(0, 1, 0, "R4"); cyc(0, 0, 1, "R4"); cyc(0, 0, 0, "R4");
        cyc(0, 1, 0, "R4"); cyc(0, 1, 0, "R4"); cyc(0, 0, 1, "R4");
        cyc(0, 0, 0, "R4");
        // data in read cycle lands in next period
        cyc(1, 0, 0, "R5"); cyc(0, 1, 1, "R5"); cyc(0, 0, 1, "R5");
        cyc(1, 0, 1, "R5"); cyc(0, 0, 0, "R6"); cyc(0, 0, 1, "R5");
        cyc(0, 0, 0, "R6"); cyc(0, 0, 0, "R6");
        // random
        for (int i = 0; i < 3000; i++) begin
            automatic int v = int'($urandom_range(0, 99));
            cyc(v < 30, (v % 3) == 0, v >= 70, "R9");
        end
        cyc(0, 0, 0, "R6");
        cyc(0, 0, 0, "R6");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule